// File: doc/BRIEF.md
# Two-Mode Burst Address Generator

This block supplies the beat addresses of a four-beat memory burst. A load strobe captures a full start address. Each advance strobe after that moves the burst to its next beat. Only the two lowest address bits change during a burst. They follow one of two orderings, chosen by a static strap input: a linear order, which adds the beat index to the start offset modulo four, or an interleaved order, which XORs the start offset with the beat index. The address bits above the beat field stay at the captured value for the whole burst.

The outputs are registered. They show the new state in the cycle after the clock edge that caused it. The outputs are the current beat address, a flag that is high on the last beat of the group, and an indication that a burst is active. After the fourth beat the sequence wraps back to the start address. A stall input freezes all state and ignores every other synchronous input. A memory controller uses the block to produce the column or word addresses of a burst from one request.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `addr_out` = 0, `burst_on` = 0 and `last_beat` = 0.
- R2: A clock edge with `stall` = 0 and `load` = 1 captures `start_addr`. In the following cycle `addr_out` equals that start address, `burst_on` = 1 and `last_beat` = 0.
- R3: With `xor_order` = 0, after k accepted advances the low two bits of `addr_out` equal (start[1:0] + k) mod 4. From a start of 1 this gives 1,2,3,0.
- R4: With `xor_order` = 1, after k accepted advances the low two bits of `addr_out` equal start[1:0] XOR (k mod 4). From a start of 2 this gives 2,3,0,1.
- R5: The fourth accepted advance of a burst returns `addr_out` to the captured start address, and `burst_on` stays 1.
- R6: Bits above bit 1 of `addr_out` stay equal to the captured start address for every beat of a burst.
- R7: `last_beat` is 1 exactly while a burst is active and the beat index (the number of accepted advances mod 4) equals 3.
- R8: A clock edge with `stall` = 1 changes none of the outputs. `load` and `advance` are ignored on that edge.
- R9: When `load` and `advance` are both 1 on an unstalled edge, the load wins: the burst restarts at beat 0 of the new start address.
- R10: An `advance` with no active burst (after reset) has no effect: `addr_out`, `burst_on` and `last_beat` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | High freezes all state and ignores the other inputs |
| load | input | 1 | Capture `start_addr` and begin a burst at beat 0 |
| advance | input | 1 | Step to the next beat of the active burst |
| xor_order | input | 1 | Static strap: 0 selects linear order, 1 selects interleaved order |
| start_addr | input | ADDR_W | Burst start address |
| addr_out | output | ADDR_W | Registered address of the current beat |
| last_beat | output | 1 | High while the current beat is the fourth of the group |
| burst_on | output | 1 | High while a burst is active |

## Verification
The assertions assume that `xor_order` is a fixed strap. It may change only between bursts, never while a burst is stepping, so that the low-bit step checks compare two beats of the same ordering. The stimulus sets the strap once at the start of each burst, before the load edge. It keeps the strap constant through all advances and stalls of that burst. The stimulus covers both orderings and all four start offsets, each with varied upper address bits. It takes every burst through the wrap, with stalled edges mixed in. It also drives coincident load and advance.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/beat_counter.sv
module beat_counter
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  load,
  input  logic  step,
  output beat_t cnt_d,
  output logic  active_d,
  output beat_t cnt_q,
  output logic  active_q
);
  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    if (en) begin
      if (load) begin
        cnt_d    = '0;
        active_d = 1'b1;
      end else if (step && active_q) begin
        cnt_d = cnt_q + beat_t'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end

  // R10
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> cnt_q == '0);

  // R8
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q) && $stable(active_q));
endmodule

// File: rtl/start_latch.sv
module start_latch #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] base_d,
  output logic [ADDR_W-1:0] base_q
);
  always_comb begin
    base_d = base_q;
    if (en && load) base_d = din;
  end

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_d;
  end

  // R2
  base_capture_chk: assert property (@(posedge clk) disable iff (rst)
    en && load |=> base_q == $past(din));
endmodule

// File: rtl/beat_order.sv
module beat_order
  import burst_pkg::*;
(
  input  order_e mode,
  input  beat_t  start_lo,
  input  beat_t  idx,
  output beat_t  lo
);
  beat_t lin_lo;
  beat_t xor_lo;

  assign lin_lo = start_lo + idx;
  assign xor_lo = start_lo ^ idx;
  assign lo     = (mode == ORDER_XOR) ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              load,
  input  logic              advance,
  input  logic              xor_order,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat,
  output logic              burst_on
);
  localparam int HI_W = ADDR_W - BEAT_W;
  localparam beat_t LAST_IDX = beat_t'(BEATS - 1);

  logic              en;
  beat_t             cnt_d, cnt_q;
  logic              act_d, act_q;
  logic [ADDR_W-1:0] base_d, base_q;
  beat_t             lo_d;
  order_e            mode;

  assign en   = !stall;
  assign mode = order_e'(xor_order);

  beat_counter u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .step     (advance),
    .cnt_d    (cnt_d),
    .active_d (act_d),
    .cnt_q    (cnt_q),
    .active_q (act_q)
  );

  start_latch #(.ADDR_W(ADDR_W)) u_base (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .load   (load),
    .din    (start_addr),
    .base_d (base_d),
    .base_q (base_q)
  );

  beat_order u_order (
    .mode     (mode),
    .start_lo (base_d[BEAT_W-1:0]),
    .idx      (cnt_d),
    .lo       (lo_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out  <= '0;
      last_beat <= 1'b0;
      burst_on  <= 1'b0;
    end else if (en) begin
      addr_out  <= {base_d[ADDR_W-1:BEAT_W], lo_d};
      last_beat <= act_d && (cnt_d == LAST_IDX);
      burst_on  <= act_d;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !burst_on && !last_beat && addr_out == '0);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(addr_out) && $stable(last_beat) && $stable(burst_on));

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    !stall && load |=> addr_out == $past(start_addr) && burst_on && !last_beat);

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    !stall && !load && advance && burst_on && !xor_order
      |=> addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + beat_t'(1));

  // R7
  last_needs_burst_chk: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> burst_on);

  // R10
  idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
    !burst_on && !load |=> !burst_on && $stable(addr_out));

  initial begin
    assert (HI_W >= 1);
  end
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 20;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst;
  logic          stall, load, advance, xor_order;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] addr_out;
  logic          last_beat, burst_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .stall(stall), .load(load), .advance(advance),
    .xor_order(xor_order), .start_addr(start_addr),
    .addr_out(addr_out), .last_beat(last_beat), .burst_on(burst_on)
  );

  task automatic check(string req, logic [AW-1:0] exp_a, logic exp_l, logic exp_b);
    checks++;
    if (addr_out !== exp_a || last_beat !== exp_l || burst_on !== exp_b) begin
      errors++;
      $display("FAIL %s: addr=%h last=%b on=%b expected addr=%h last=%b on=%b",
               req, addr_out, last_beat, burst_on, exp_a, exp_l, exp_b);
    end
  endtask

  task automatic cyc(logic s, logic l, logic a, logic [AW-1:0] sa);
    stall = s; load = l; advance = a; start_addr = sa;
    @(posedge clk);
    @(negedge clk);
    stall = 0; load = 0; advance = 0;
  endtask

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] st, logic m, int k);
    logic [1:0] lo;
    lo = m ? (st[1:0] ^ 2'(k % 4)) : 2'((st[1:0] + k) % 4);
    return {st[AW-1:2], lo};
  endfunction

  initial begin
    rst = 1; stall = 0; load = 0; advance = 0; xor_order = 0; start_addr = '0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", '0, 0, 0);
    rst = 0;
    // R10 advance with no burst is ignored
    cyc(0, 0, 1, 20'hABCDE);
    check("R10", '0, 0, 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] st;
        st = {18'(32'h2A5C3 * (s + 1) + m * 7), 2'(s)};
        xor_order = m[0];
        cyc(0, 1, 0, st);
        // R2 load
        check("R2", st, 0, 1);
        for (int k = 1; k <= 5; k++) begin
          // R8 stall: inputs ignored
          cyc(1, 1, 1, ~st);
          check("R8", expect_addr(st, m[0], k - 1), ((k - 1) % 4) == 3, 1);
          cyc(0, 0, 1, ~st);
          // R3 linear, R4 interleave, R6 upper, R7 last, R5 wrap
          if (m == 0) check("R3", expect_addr(st, 0, k), (k % 4) == 3, 1);
          else        check("R4", expect_addr(st, 1, k), (k % 4) == 3, 1);
          if (k == 4) check("R5", st, 0, 1);
          if (k == 3) check("R7", expect_addr(st, m[0], 3), 1, 1);
          if (addr_out[AW-1:2] !== st[AW-1:2]) begin
            errors++;
            $display("FAIL R6: upper=%h expected %h", addr_out[AW-1:2], st[AW-1:2]);
          end
          checks++;
        end
      end
    end

    // R9 load beats advance
    xor_order = 0;
    cyc(0, 1, 0, 20'h12341);
    cyc(0, 0, 1, 20'h0);
    cyc(0, 1, 1, 20'h55552);
    check("R9", 20'h55552, 0, 1);
    cyc(0, 0, 1, 20'h0);
    check("R9", 20'h55553, 0, 1);

    // R1 reset mid-burst
    rst = 1;
    cyc(0, 0, 1, 20'h0);
    rst = 0;
    check("R1", '0, 0, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule